// File: doc/BRIEF.md
# Configurable SPI Frame Master

This block drives a four-wire serial link as the clocking side. It generates the serial clock, the outgoing data line and an active-low chip select, and it captures the incoming data line in the same bit slots, so every frame sent also brings one frame back. Software owns the chip select through a select level. It pushes one frame at a time into a single-entry transmit holder and collects results from a single-entry receive holder.

Configuration inputs set the frame length (4 to 16 bits), the bit order, the clock idle level and the clock phase. They also set the serial clock rate as an even division of the system clock, and the number of idle serial clock periods placed between frames. A transmit-only setting leaves the receive side untouched, for links where only the outgoing direction matters. Three level interrupt requests follow the transmit-empty, receive-full and idle flags, each behind its own enable. An overrun flag records that a result was replaced before software collected it.

Top module: `spi_frame_master`

## Requirements
- R1: The serial clock toggles every H system clock cycles while a frame is shifted, where H is the `cfg_half` input (a value of 0 acts as 1), giving an even divisor 2·H of at least 2.
- R2: Whenever no frame is being shifted, `sck` sits at the level given by `cfg_cpol`.
- R3: A frame of W bits produces exactly 2·W serial clock edges. With `cfg_cpha`=0 both sides sample on the first edge of each bit and `mosi` changes on the second edge. With `cfg_cpha`=1 `mosi` changes on the first edge and both sides sample on the second edge.
- R4: The effective frame length W is `cfg_width` clamped to the range 4..16. Received frames appear right-aligned in `rx_data` with bits above W at zero.
- R5: With `cfg_lsb_first`=0 bit W-1 of the frame goes out and comes in first. With `cfg_lsb_first`=1 bit 0 goes first.
- R6: `cs_n` equals `sel_hi`. A frame starts only while `cs_n` is low, the transmit holder is full and no frame or gap is in progress.
- R7: `txe` is 1 while the transmit holder is empty. A `tx_wr` pulse while `txe`=1 fills it, and starting a frame empties it. A `tx_wr` while `txe`=0 is ignored and that value is never sent.
- R8: One cycle after the last edge of a frame, `rxne` is set and `rx_data` takes the new frame; `rx_rd` clears `rxne`. A new frame arriving while `rxne`=1 replaces the held one and sets `ovr`, which stays set until an `ovr_clr` pulse.
- R9: With a next frame already held, the time from the last clock edge of one frame to the first clock edge of the next is (2·G+1)·H+1 system cycles, where G is `cfg_gap` (0..15 serial clock periods of extra idle time).
- R10: With `cfg_tx_only`=1 frames still go out on `mosi`, `rxne` never rises and `rx_data` keeps its value. The transfer is complete when `txe`=1 and `busy`=0.
- R11: `irq[0]`, `irq[1]` and `irq[2]` equal `txe`, `rxne` and `!busy`, each gated by the matching bit of `irq_en`.
- R12: After reset `txe`=1, `rxne`=0, `busy`=0 and `ovr`=0, and no serial clock edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 5 | Requested frame length in bits (clamped to 4..16) |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on first edge; 1: sample on second edge |
| cfg_half | input | 8 | Serial clock half-period in system cycles |
| cfg_gap | input | 4 | Idle serial clock periods between frames |
| cfg_tx_only | input | 1 | Transmit-only half-duplex operation |
| sel_hi | input | 1 | Chip select level driven by software (0 selects) |
| tx_wr | input | 1 | Write strobe for the transmit holder |
| tx_data | input | 16 | Frame to transmit, right-aligned |
| rx_rd | input | 1 | Read strobe that clears `rxne` |
| ovr_clr | input | 1 | Clear strobe for `ovr` |
| irq_en | input | 3 | Enables for the three interrupt requests |
| rx_data | output | 16 | Last received frame, right-aligned |
| txe | output | 1 | Transmit holder empty |
| rxne | output | 1 | Receive holder full |
| busy | output | 1 | Frame or inter-frame gap in progress |
| ovr | output | 1 | Received frame replaced an unread one |
| irq | output | 3 | Interrupt requests {idle, receive full, transmit empty} |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Outgoing serial data |
| miso | input | 1 | Incoming serial data |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit maximum and 4-bit minimum frame length, an 8-bit half-period field and a 4-bit gap field. With these, both ends of the length clamp, a divisor of 2 and a multi-cycle half-period, and gaps of zero and several clock periods all lie within the stimulus. A bench-side peripheral model captures `mosi` and drives `miso` on the edges R3 names. It measures edge spacing and inter-frame idle time in system cycles against R1 and R9. All four clock modes and both bit orders run through the vector table, and directed runs cover the held chip select, ignored writes, overrun, transmit-only operation and the clamp.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } eng_state_t;
endpackage

// File: rtl/spi_half_div.sv
module spi_half_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] half_eff;

   assign half_eff = (half == '0) ? DIV_W'(1) : half;
   assign tick     = run && (cnt_q == half_eff - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   // R1: the counter never runs past the half-period while the setting holds
   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $stable(half)) |-> (cnt_q < half_eff));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_frame_pkg::*;
#(
   parameter int MAX_W = 16,
   parameter int CNT_W = 5,
   parameter int DIV_W = 8,
   parameter int GAP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [MAX_W-1:0] tx_frame,
   input  logic [CNT_W-1:0] width,
   input  logic             lsb_first,
   input  logic             cpol,
   input  logic             cpha,
   input  logic [DIV_W-1:0] half,
   input  logic [GAP_W-1:0] gap,
   input  logic             miso,
   output logic             sck,
   output logic             mosi,
   output logic             busy,
   output logic             done,
   output logic [MAX_W-1:0] rx_frame
);
   localparam int E_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] FULL_W = CNT_W'(MAX_W);

   eng_state_t       st_q;
   logic [E_W-1:0]   ecnt_q;
   logic             phase_q;
   logic [MAX_W-1:0] tx_sh_q;
   logic [MAX_W-1:0] rx_sh_q;
   logic [GAP_W:0]   gcnt_q;
   logic             done_q;
   logic             tick;
   logic [E_W-1:0]   last_idx;
   logic [GAP_W:0]   gap_last;
   logic             edge_tick, is_last, sample_ev, shift_ev;

   assign last_idx  = {width, 1'b0} - E_W'(1);
   assign gap_last  = {gap, 1'b0} - (GAP_W+1)'(1);
   assign edge_tick = tick && (st_q == ST_SHIFT);
   assign is_last   = (ecnt_q == last_idx);
   assign sample_ev = edge_tick && (cpha ? phase_q : !phase_q);
   assign shift_ev  = edge_tick && (cpha ? (!phase_q && ecnt_q != '0)
                                         : (phase_q && !is_last));

   spi_half_div #(.DIV_W(DIV_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st_q != ST_IDLE),
      .half (half),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         ecnt_q  <= '0;
         phase_q <= 1'b0;
         tx_sh_q <= '0;
         rx_sh_q <= '0;
         gcnt_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= edge_tick && is_last;
         case (st_q)
            ST_IDLE: if (start) begin
               st_q    <= ST_SHIFT;
               tx_sh_q <= tx_frame;
               rx_sh_q <= '0;
               ecnt_q  <= '0;
               phase_q <= 1'b0;
            end
            ST_SHIFT: if (tick) begin
               phase_q <= !phase_q;
               ecnt_q  <= ecnt_q + 1'b1;
               if (shift_ev)
                  tx_sh_q <= lsb_first ? (tx_sh_q >> 1) : (tx_sh_q << 1);
               if (sample_ev)
                  rx_sh_q <= lsb_first ? {miso, rx_sh_q[MAX_W-1:1]}
                                       : {rx_sh_q[MAX_W-2:0], miso};
               if (is_last) begin
                  gcnt_q <= '0;
                  st_q   <= (gap == '0) ? ST_IDLE : ST_GAP;
               end
            end
            ST_GAP: if (tick) begin
               gcnt_q <= gcnt_q + 1'b1;
               if (gcnt_q == gap_last) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sck      = cpol ^ phase_q;
   assign mosi     = lsb_first ? tx_sh_q[0] : tx_sh_q[width - CNT_W'(1)];
   assign busy     = (st_q != ST_IDLE);
   assign done     = done_q;
   assign rx_frame = lsb_first ? (rx_sh_q >> (FULL_W - width))
                               : (rx_sh_q & ({MAX_W{1'b1}} >> (FULL_W - width)));

   // R3: a frame always ends with the clock back on its idle side
   a_r3_phase_home: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == ST_SHIFT && st_q != ST_SHIFT) |-> !phase_q);

   // R3: outgoing data only moves on a shifting edge
   a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SHIFT && $past(st_q) == ST_SHIFT && !$past(shift_ev)
       && $stable(lsb_first) && $stable(width)) |-> $stable(mosi));

   // R9: no clock activity during the inter-frame gap
   a_r9_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_GAP && $past(st_q) == ST_GAP && $stable(cpol)) |-> $stable(sck));
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
   parameter int MAX_W = 16,
   parameter int MIN_W = 4,
   parameter int DIV_W = 8,
   parameter int GAP_W = 4,
   localparam int CNT_W = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_width,
   input  logic             cfg_lsb_first,
   input  logic             cfg_cpol,
   input  logic             cfg_cpha,
   input  logic [DIV_W-1:0] cfg_half,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic             cfg_tx_only,
   input  logic             sel_hi,
   input  logic             tx_wr,
   input  logic [MAX_W-1:0] tx_data,
   input  logic             rx_rd,
   input  logic             ovr_clr,
   input  logic [2:0]       irq_en,
   output logic [MAX_W-1:0] rx_data,
   output logic             txe,
   output logic             rxne,
   output logic             busy,
   output logic             ovr,
   output logic [2:0]       irq,
   output logic             sck,
   output logic             mosi,
   input  logic             miso,
   output logic             cs_n
);
   localparam logic [CNT_W-1:0] LO_W = CNT_W'(MIN_W);
   localparam logic [CNT_W-1:0] HI_W = CNT_W'(MAX_W);

   if (MIN_W < 2 || MAX_W < MIN_W || DIV_W < 1 || GAP_W < 1) begin : g_bad_cfg
      $error("spi_frame_master: inconsistent parameters");
   end

   logic [CNT_W-1:0] width_eff;
   logic [MAX_W-1:0] tx_buf_q, rx_buf_q, eng_rx;
   logic             tx_full_q, rx_full_q, ovr_q;
   logic             eng_busy, eng_done, start;
   logic [2:0]       stat;

   assign width_eff = (cfg_width < LO_W) ? LO_W : (cfg_width > HI_W) ? HI_W : cfg_width;
   assign start     = tx_full_q && !sel_hi && !eng_busy;

   spi_shift_engine #(
      .MAX_W(MAX_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .GAP_W(GAP_W)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tx_frame (tx_buf_q),
      .width    (width_eff),
      .lsb_first(cfg_lsb_first),
      .cpol     (cfg_cpol),
      .cpha     (cfg_cpha),
      .half     (cfg_half),
      .gap      (cfg_gap),
      .miso     (miso),
      .sck      (sck),
      .mosi     (mosi),
      .busy     (eng_busy),
      .done     (eng_done),
      .rx_frame (eng_rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf_q  <= '0;
         tx_full_q <= 1'b0;
      end else if (tx_wr && !tx_full_q) begin
         tx_buf_q  <= tx_data;
         tx_full_q <= 1'b1;
      end else if (start) begin
         tx_full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf_q  <= '0;
         rx_full_q <= 1'b0;
         ovr_q     <= 1'b0;
      end else begin
         if (ovr_clr) ovr_q <= 1'b0;
         if (eng_done && !cfg_tx_only) begin
            rx_buf_q  <= eng_rx;
            rx_full_q <= 1'b1;
            if (rx_full_q && !rx_rd) ovr_q <= 1'b1;
         end else if (rx_rd) begin
            rx_full_q <= 1'b0;
         end
      end
   end

   assign stat = {!eng_busy, rx_full_q, !tx_full_q};
   for (genvar gi = 0; gi < 3; gi++) begin : g_irq
      assign irq[gi] = stat[gi] & irq_en[gi];
   end

   assign txe     = !tx_full_q;
   assign rxne    = rx_full_q;
   assign busy    = eng_busy;
   assign ovr     = ovr_q;
   assign rx_data = rx_buf_q;
   assign cs_n    = sel_hi;

   // R7: an accepted write leaves the holder full on the next cycle
   a_r7_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && txe) |=> !txe);

   // R7: a write into a full holder does not disturb it
   a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && tx_full_q && !start) |=> $stable(tx_buf_q));

   // R6: activity starts only with select low and a frame held
   a_r6_start_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(!cs_n) && $past(!txe)));

   // R8: overrun rises only over a result already held
   a_r8_ovr_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(rxne));

   // R10: transmit-only operation never reports a received frame
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_tx_only && $past(cfg_tx_only)) |-> !$rose(rxne));
endmodule

// File: tb/spi_frame_master_tb_top.sv
module spi_frame_master_tb_top;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic [4:0]  w;
      logic        lsb;
      logic        cpol;
      logic        cpha;
      logic [7:0]  half;
      logic [15:0] tx;
      logic [15:0] slv;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{5'd8,  1'b0, 1'b0, 1'b0, 8'd2, 16'h00A5, 16'h003C},
      '{5'd8,  1'b1, 1'b0, 1'b1, 8'd1, 16'h0096, 16'h00C3},
      '{5'd16, 1'b0, 1'b1, 1'b0, 8'd3, 16'hBEEF, 16'h1234},
      '{5'd4,  1'b1, 1'b1, 1'b1, 8'd2, 16'h0009, 16'h0006},
      '{5'd12, 1'b0, 1'b0, 1'b1, 8'd1, 16'h0ABC, 16'h05A3},
      '{5'd5,  1'b1, 1'b1, 1'b0, 8'd4, 16'h0013, 16'h000A}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0]  cfg_width = 5'd8;
   logic        cfg_lsb_first = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [7:0]  cfg_half = 8'd2;
   logic [3:0]  cfg_gap = 4'd0;
   logic        cfg_tx_only = 1'b0;
   logic        sel_hi = 1'b1, tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
   logic [15:0] tx_data = '0;
   logic [2:0]  irq_en = 3'b111;
   logic [15:0] rx_data;
   logic        txe, rxne, busy, ovr, sck, mosi, miso, cs_n;
   logic [2:0]  irq;

   spi_frame_master dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_lsb_first(cfg_lsb_first),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_half(cfg_half), .cfg_gap(cfg_gap),
      .cfg_tx_only(cfg_tx_only), .sel_hi(sel_hi), .tx_wr(tx_wr), .tx_data(tx_data),
      .rx_rd(rx_rd), .ovr_clr(ovr_clr), .irq_en(irq_en), .rx_data(rx_data), .txe(txe),
      .rxne(rxne), .busy(busy), .ovr(ovr), .irq(irq), .sck(sck), .mosi(mosi),
      .miso(miso), .cs_n(cs_n)
   );

   always #(CLK_P/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // peripheral model settings, written only by the stimulus process
   int          cur_w = 8, cur_half = 2;
   logic        cur_lsb = 1'b0, cur_cpol = 1'b0, cur_cpha = 1'b0;
   logic [15:0] slv_words [8];
   int          arm_gen = 0;

   // peripheral model state, written only by the monitor
   int          seen_gen = 0, mon_k = 0, mon_n = 0, slv_idx = 0;
   int          edge_in_frame = 0, edge_total = 0, spacing_bad = 0;
   int          last_edge_cyc = 0, gap_last = -1;
   bit          have_last = 1'b0;
   logic        prev_sck = 1'b0;
   logic [15:0] mon_acc = '0;
   logic [15:0] mon_words [8];
   logic [15:0] cur_slv;

   assign cur_slv = slv_words[slv_idx & 7];
   assign miso = cur_lsb ? cur_slv[mon_k & 15] : cur_slv[(cur_w - 1 - mon_k) & 15];

   always @(negedge clk) begin
      if (arm_gen != seen_gen) begin
         seen_gen = arm_gen; mon_k = 0; mon_n = 0; slv_idx = 0;
         edge_in_frame = 0; edge_total = 0; spacing_bad = 0;
         have_last = 1'b0; gap_last = -1; mon_acc = '0;
      end else if (rst_n && !cs_n && sck !== prev_sck) begin
         if (edge_in_frame != 0 && (cyc - last_edge_cyc) != cur_half) spacing_bad++;
         if (edge_in_frame == 0 && have_last) gap_last = cyc - last_edge_cyc;
         last_edge_cyc = cyc;
         have_last = 1'b1;
         edge_total++;
         edge_in_frame++;
         if ((prev_sck == cur_cpol) != cur_cpha) begin
            if (cur_lsb) mon_acc[mon_k & 15] = mosi;
            else         mon_acc[(cur_w - 1 - mon_k) & 15] = mosi;
            mon_k++;
            if (mon_k == cur_w) begin
               mon_words[mon_n & 7] = mon_acc;
               mon_n++; mon_k = 0; mon_acc = '0; slv_idx++;
            end
         end
         if (edge_in_frame == 2 * cur_w) edge_in_frame = 0;
      end
      prev_sck = sck;
   end

   int n_chk = 0, n_err = 0;
   bit done_flag = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive_cfg(input int w, input logic lsb, input logic cpol,
                            input logic cpha, input int half, input int gap);
      @(posedge clk); #1;
      cfg_width = 5'(w); cfg_lsb_first = lsb; cfg_cpol = cpol; cfg_cpha = cpha;
      cfg_half = 8'(half); cfg_gap = 4'(gap);
   endtask

   task automatic arm(input int w_eff, input logic [15:0] s0, input logic [15:0] s1);
      cur_w = w_eff; cur_half = (cfg_half == 0) ? 1 : int'(cfg_half);
      cur_lsb = cfg_lsb_first; cur_cpol = cfg_cpol; cur_cpha = cfg_cpha;
      slv_words[0] = s0; slv_words[1] = s1;
      for (int k = 2; k < 8; k++) slv_words[k] = '0;
      arm_gen++;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic write_tx(input logic [15:0] v);
      @(posedge clk); #1; tx_wr = 1'b1; tx_data = v;
      @(posedge clk); #1; tx_wr = 1'b0;
   endtask

   task automatic pulse_rd;
      @(posedge clk); #1; rx_rd = 1'b1;
      @(posedge clk); #1; rx_rd = 1'b0;
   endtask

   task automatic pulse_clr;
      @(posedge clk); #1; ovr_clr = 1'b1;
      @(posedge clk); #1; ovr_clr = 1'b0;
   endtask

   task automatic set_sel(input logic v);
      @(posedge clk); #1; sel_hi = v;
   endtask

   task automatic wait_rxne(input string tag);
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (rxne) return;
      end
      chk({tag, " timeout waiting for rxne"}, 0, 1);
   endtask

   task automatic wait_txe(input string tag);
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (txe) return;
      end
      chk({tag, " timeout waiting for txe"}, 0, 1);
   endtask

   task automatic wait_idle(input string tag);
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (txe && !busy) return;
      end
      chk({tag, " timeout waiting for idle"}, 0, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] mask, held;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R12: reset state; irq[2:0] = {!busy, rxne, txe} with all enables on
      chk("R12 txe", txe, 1); chk("R12 rxne", rxne, 0);
      chk("R12 busy", busy, 0); chk("R12 ovr", ovr, 0);
      chk("R12 sck at idle", sck, 0); chk("R6 cs_n follows select", cs_n, 1);
      chk("R11 irq after reset", irq, 3'b101);

      // table of modes, lengths, orders and rates (R1 R2 R3 R4 R5 R8)
      irq_en = 3'b000;
      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         v = VECS[i];
         mask = 16'((32'h1 << v.w) - 1);
         drive_cfg(int'(v.w), v.lsb, v.cpol, v.cpha, int'(v.half), 0);
         arm(int'(v.w), v.slv, 16'h0);
         set_sel(1'b0);
         write_tx(v.tx);
         wait_rxne($sformatf("R8 vec%0d", i));
         chk($sformatf("R5 vec%0d mosi frame", i), mon_words[0], v.tx & mask);
         chk($sformatf("R4 vec%0d rx_data", i), rx_data, v.slv & mask);
         chk($sformatf("R3 vec%0d edge count", i), edge_total, 2 * v.w);
         chk($sformatf("R1 vec%0d edge spacing errors", i), spacing_bad, 0);
         chk($sformatf("R2 vec%0d sck idle level", i), sck, v.cpol);
         pulse_rd;
         @(negedge clk);
         chk($sformatf("R8 vec%0d rxne cleared", i), rxne, 0);
         set_sel(1'b1);
      end

      // R9 and R8: back-to-back frames, gap of 3 clock periods, no read between
      drive_cfg(4, 1'b0, 1'b0, 1'b0, 2, 3);
      arm(4, 16'h5, 16'hA);
      set_sel(1'b0);
      write_tx(16'h3);
      wait_txe("R9 gap3");
      write_tx(16'hC);
      wait_idle("R9 gap3");
      repeat (3) @(negedge clk);
      chk("R9 gap3 idle cycles", gap_last, (2*3+1)*2 + 1);
      chk("R7 second frame sent", mon_words[1], 16'hC);
      chk("R8 overrun flag", ovr, 1);
      chk("R8 newest frame kept", rx_data, 16'hA);
      pulse_clr;
      @(negedge clk);
      chk("R8 ovr cleared", ovr, 0);
      chk("R8 rxne survives ovr clear", rxne, 1);
      pulse_rd;
      set_sel(1'b1);

      // R9: zero gap
      drive_cfg(4, 1'b0, 1'b0, 1'b0, 2, 0);
      arm(4, 16'h1, 16'h2);
      set_sel(1'b0);
      write_tx(16'h7);
      wait_txe("R9 gap0");
      write_tx(16'h8);
      wait_idle("R9 gap0");
      repeat (3) @(negedge clk);
      chk("R9 gap0 idle cycles", gap_last, 3);
      pulse_rd; pulse_clr;
      set_sel(1'b1);

      // R6 and R7: frame held while deselected; extra write while full is dropped
      drive_cfg(8, 1'b0, 1'b1, 1'b1, 1, 0);
      arm(8, 16'h66, 16'h00);
      write_tx(16'h81);
      repeat (20) @(negedge clk);
      chk("R6 no start while deselected", busy, 0);
      chk("R6 no clock edges while deselected", edge_total, 0);
      chk("R7 txe low with held frame", txe, 0);
      write_tx(16'h42);
      set_sel(1'b0);
      wait_rxne("R6 after select");
      repeat (40) @(negedge clk);
      chk("R7 held frame sent", mon_words[0], 16'h81);
      chk("R7 dropped write not sent", mon_n, 1);
      chk("R7 txe after frame", txe, 1);
      pulse_rd;
      held = rx_data;

      // R10 and R11: transmit-only
      irq_en = 3'b111;
      @(posedge clk); #1 cfg_tx_only = 1'b1;
      drive_cfg(8, 1'b1, 1'b0, 1'b0, 2, 0);
      arm(8, 16'hFF, 16'h00);
      write_tx(16'h5B);
      wait_idle("R10");
      repeat (3) @(negedge clk);
      chk("R10 frame on mosi", mon_words[0], 16'h5B);
      chk("R10 rxne stays low", rxne, 0);
      chk("R10 rx_data unchanged", rx_data, held);
      chk("R11 irq idle and txe", irq, 3'b101);
      @(posedge clk); #1 cfg_tx_only = 1'b0; irq_en = 3'b010;
      arm(8, 16'h3E, 16'h00);
      write_tx(16'h11);
      wait_rxne("R11");
      @(negedge clk);
      chk("R11 irq receive only", irq, 3'b010);
      chk("R8 full-duplex after tx-only", rx_data, 16'h3E);
      pulse_rd;

      // R4: length clamp at both ends
      drive_cfg(1, 1'b0, 1'b0, 1'b1, 1, 0);
      arm(4, 16'h9, 16'h0);
      write_tx(16'hFFF6);
      wait_rxne("R4 low clamp");
      chk("R4 low clamp edges", edge_total, 8);
      chk("R4 low clamp rx", rx_data, 16'h9);
      chk("R4 low clamp mosi", mon_words[0], 16'h6);
      pulse_rd;
      drive_cfg(31, 1'b1, 1'b0, 1'b0, 1, 0);
      arm(16, 16'hC0DE, 16'h0);
      write_tx(16'h1357);
      wait_rxne("R4 high clamp");
      chk("R4 high clamp edges", edge_total, 32);
      chk("R4 high clamp rx", rx_data, 16'hC0DE);
      pulse_rd;
      set_sel(1'b1);

      repeat (5) @(negedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule